// File: doc/BRIEF.md
# Packet VM Arithmetic Execution Unit

This unit executes the arithmetic class of a 64-bit register virtual machine used for packet filtering. A decoder presents the 4-bit operation code, a 16-bit offset field, a mode flag (64-bit or 32-bit), a bit that chooses the immediate or the source register, the current destination value, the source register value and a 32-bit immediate. A one-cycle `start` pulse hands the operation over. The unit returns the new destination value on `result` and pulses `done` for one cycle.

Most operations finish in a single cycle. Division and modulo go through an iterative restoring divider that retires one quotient bit per cycle. While it runs, `busy` is held high and any new `start` is ignored. Results are defined in every case: division or modulo by zero, the most negative value divided by -1, and shift counts beyond the operand width.

Codes 0xd to 0xf are not part of this unit. They return the destination operand, reduced to its low half in 32-bit mode.

Top module: `pvm_alu`

## Requirements
- R1: Codes ADD 0x0, SUB 0x1, MUL 0x2, OR 0x4, AND 0x5, NEG 0x8 (negates the destination), XOR 0xa and MOV 0xb (offset 0) produce wrapped results. `done` is high in the cycle after the accepting clock edge.
- R2: With `use_reg` = 0 the operand is the immediate; with `use_reg` = 1 it is `src_in`.
- R3: In 32-bit mode (`wide` = 0) only the low 32 bits of the operands are used, and every result has bits 63:32 cleared.
- R4: In 64-bit mode the immediate is sign-extended to 64 bits before use. Unsigned divide and modulo then treat it as an unsigned 64-bit value.
- R5: LSH 0x6, RSH 0x7 (logical) and ARSH 0xc (fills with the sign bit) use the operand masked to 6 bits in 64-bit mode and to 5 bits in 32-bit mode as the shift count.
- R6: Code 0xb with offset 8, 16 or 32 sign-extends that many low operand bits. In 32-bit mode the result is then zero-extended from bit 31.
- R7: Codes 0x3 (divide) and 0x9 (modulo) are unsigned when the offset is 0 and signed when the offset is 1. Signed quotients truncate toward zero, and a signed remainder takes the dividend's sign (-13 mod 3 = -1).
- R8: Divide by zero yields 0. Modulo by zero yields the destination unchanged in 64-bit mode, and its low 32 bits zero-extended in 32-bit mode.
- R9: Signed divide of the most negative value by -1 yields the most negative value, and the matching modulo yields 0.
- R10: A divide or modulo holds `busy` for 64 cycles (64-bit mode) or 32 cycles (32-bit mode), then drops `busy` and pulses `done` with the result. `start` is ignored while `busy` is high, and `busy` and `done` are never high together.
- R11: During reset `busy`, `done` and `result` are 0.
- R12: `result` changes only in a cycle in which `done` is high, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch the presented operation |
| op | input | 4 | Operation code |
| ofs | input | 16 | Offset field selecting signed or sign-extending variants |
| wide | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| use_reg | input | 1 | 1 = source register operand, 0 = immediate operand |
| dst_in | input | XLEN | Current destination register value |
| src_in | input | XLEN | Source register value |
| imm | input | XLEN/2 | Immediate |
| busy | output | 1 | Divider running |
| done | output | 1 | One-cycle pulse with a new result |
| result | output | XLEN | New destination value |

## Verification
The sweep crosses every operation and offset variant, both modes and both operand sources, over a set of values chosen for the corners. That set includes zero, ±1, -13 with 3, both most-negative values, and shift counts 33 and 63.

Each corner catches a specific mistake:
- A divider that skips the zero-divisor override would return all ones or the dividend instead of 0.
- A modulo by zero that forgets to clear the upper half would leak dst bits in 32-bit mode.
- A modulo that floors instead of truncating gives 2 for -13 mod 3.
- A missing shift mask would shift a 32-bit value by 33 and produce zero.
- An unguarded sign fix-up on MIN / -1 would produce a wrong sign.

A second `start` is injected mid-division, which shows whether an unprotected handshake restarts or corrupts the running divide.

// File: rtl/pvm_alu.sv
module pvm_alu #(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        op,
  input  logic [15:0]       ofs,
  input  logic              wide,
  input  logic              use_reg,
  input  logic [XLEN-1:0]   dst_in,
  input  logic [XLEN-1:0]   src_in,
  input  logic [XLEN/2-1:0] imm,
  output logic              busy,
  output logic              done,
  output logic [XLEN-1:0]   result
);
  localparam int HALF = XLEN / 2;
  localparam int SHW  = $clog2(XLEN);
  localparam int CW   = SHW + 1;
  localparam logic [CW-1:0] N_FULL = CW'(XLEN);
  localparam logic [CW-1:0] N_HALF = CW'(HALF);
  localparam logic [HALF-1:0] ZH = '0;

  logic [XLEN-1:0] b_sel, a_op, b_op, movx, arsh_full, arsh, alu_raw, fast;
  logic [HALF-1:0] arsh_lo;
  logic [SHW-1:0]  shamt;
  logic            accept, is_div, sgn, a_neg, b_neg;
  logic [XLEN-1:0] a_abs, b_abs, b_abs_m;

  assign b_sel = use_reg ? src_in : {{HALF{imm[HALF-1]}}, imm};
  assign a_op  = wide ? dst_in : {ZH, dst_in[HALF-1:0]};
  assign b_op  = wide ? b_sel  : {ZH, b_sel[HALF-1:0]};
  assign shamt = wide ? b_op[SHW-1:0] : {1'b0, b_op[SHW-2:0]};

  assign arsh_full = $signed(a_op) >>> shamt;
  assign arsh_lo   = $signed(a_op[HALF-1:0]) >>> shamt;
  assign arsh      = wide ? arsh_full : {ZH, arsh_lo};

  always_comb begin
    case (ofs)
      16'd8:        movx = {{(XLEN-8){b_op[7]}}, b_op[7:0]};
      16'd16:       movx = {{(XLEN-16){b_op[15]}}, b_op[15:0]};
      16'(HALF):    movx = {{HALF{b_op[HALF-1]}}, b_op[HALF-1:0]};
      default:      movx = b_op;
    endcase
  end

  always_comb begin
    case (op)
      4'h0:    alu_raw = a_op + b_op;
      4'h1:    alu_raw = a_op - b_op;
      4'h2:    alu_raw = a_op * b_op;
      4'h4:    alu_raw = a_op | b_op;
      4'h5:    alu_raw = a_op & b_op;
      4'h6:    alu_raw = a_op << shamt;
      4'h7:    alu_raw = a_op >> shamt;
      4'h8:    alu_raw = '0 - a_op;
      4'ha:    alu_raw = a_op ^ b_op;
      4'hb:    alu_raw = movx;
      4'hc:    alu_raw = arsh;
      default: alu_raw = a_op;
    endcase
  end
  assign fast = wide ? alu_raw : {ZH, alu_raw[HALF-1:0]};

  assign accept  = start && !busy;
  assign is_div  = (op == 4'h3) || (op == 4'h9);
  assign sgn     = (ofs == 16'd1);
  assign a_neg   = sgn && (wide ? a_op[XLEN-1] : a_op[HALF-1]);
  assign b_neg   = sgn && (wide ? b_op[XLEN-1] : b_op[HALF-1]);
  assign a_abs   = a_neg ? '0 - a_op : a_op;
  assign b_abs   = b_neg ? '0 - b_op : b_op;
  assign b_abs_m = wide ? b_abs : {ZH, b_abs[HALF-1:0]};

  logic [XLEN-1:0] quo, rem, dvs, keep, nquo, nrem, qv, rv, pick, fin;
  logic [XLEN:0]   trial;
  logic [CW-1:0]   cnt;
  logic            m_wide, m_mod, m_negq, m_negr, m_zero, fits;

  assign trial = {rem, quo[XLEN-1]} - {1'b0, dvs};
  assign fits  = !trial[XLEN];
  assign nrem  = fits ? trial[XLEN-1:0] : {rem[XLEN-2:0], quo[XLEN-1]};
  assign nquo  = {quo[XLEN-2:0], fits};
  assign qv    = m_negq ? '0 - nquo : nquo;
  assign rv    = m_negr ? '0 - nrem : nrem;
  assign pick  = m_zero ? (m_mod ? keep : '0) : (m_mod ? rv : qv);
  assign fin   = m_wide ? pick : {ZH, pick[HALF-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      result <= '0;
      quo    <= '0;
      rem    <= '0;
      dvs    <= '0;
      keep   <= '0;
      cnt    <= '0;
      m_wide <= 1'b0;
      m_mod  <= 1'b0;
      m_negq <= 1'b0;
      m_negr <= 1'b0;
      m_zero <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        m_wide <= wide;
        if (is_div) begin
          busy   <= 1'b1;
          cnt    <= wide ? N_FULL : N_HALF;
          quo    <= wide ? a_abs : {a_abs[HALF-1:0], ZH};
          rem    <= '0;
          dvs    <= b_abs_m;
          keep   <= a_op;
          m_mod  <= (op == 4'h9);
          m_negq <= a_neg ^ b_neg;
          m_negr <= a_neg;
          m_zero <= (b_op == '0);
        end else begin
          result <= fast;
          done   <= 1'b1;
        end
      end else if (busy) begin
        quo <= nquo;
        rem <= nrem;
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          result <= fin;
        end
      end
    end
  end
endmodule

// File: rtl/pvm_alu_chk.sv
module pvm_alu_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            m_wide,
  input logic [XLEN-1:0] result
);
  localparam int CW = $clog2(XLEN) + 2;
  localparam logic [CW-1:0] LEN_FULL = CW'(XLEN);
  localparam logic [CW-1:0] LEN_HALF = CW'(XLEN / 2);

  logic [CW-1:0] busy_run;
  always_ff @(posedge clk) begin
    if (!rst_n) busy_run <= '0;
    else        busy_run <= busy ? busy_run + 1'b1 : '0;
  end

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R10
  AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R10
  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_run == (m_wide ? LEN_FULL : LEN_HALF)); // R10
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result)); // R12
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !m_wide) |-> result[XLEN-1:XLEN/2] == '0); // R3
endmodule

bind pvm_alu pvm_alu_chk #(.XLEN(XLEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .m_wide(m_wide), .result(result)
);

// File: tb/pvm_alu_tb_top.sv
module pvm_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, start, wide, use_reg;
  logic [3:0]  op;
  logic [15:0] ofs;
  logic [63:0] dst_in, src_in, result;
  logic [31:0] imm;
  logic        busy, done;
  int n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  pvm_alu dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .ofs(ofs), .wide(wide),
    .use_reg(use_reg), .dst_in(dst_in), .src_in(src_in), .imm(imm),
    .busy(busy), .done(done), .result(result)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  function automatic logic [63:0] val(input int i);
    case (i)
      0: return 64'd0;
      1: return 64'd1;
      2: return 64'hffff_ffff_ffff_ffff;
      3: return 64'd3;
      4: return 64'hffff_ffff_ffff_fff3;
      5: return 64'd63;
      6: return 64'd33;
      7: return 64'h0000_0000_8000_0000;
      8: return 64'h8000_0000_0000_0000;
      9: return 64'hfedc_ba98_7654_3210;
      default: return 64'h7fff_ffff_ffff_ffff;
    endcase
  endfunction

  function automatic logic [63:0] model(input logic [3:0] o, input logic [15:0] f,
      input logic w, input logic ur, input logic [63:0] d, input logic [63:0] s,
      input logic [31:0] im);
    logic [63:0] a, b, r;
    int unsigned sh;
    int x;
    longint sa, sb;
    b = ur ? s : {{32{im[31]}}, im};
    a = d;
    if (!w) begin a = {32'h0, d[31:0]}; b = {32'h0, b[31:0]}; end
    sh = w ? int'(b[5:0]) : int'(b[4:0]);
    case (o)
      4'h0: r = a + b;
      4'h1: r = a - b;
      4'h2: r = a * b;
      4'h4: r = a | b;
      4'h5: r = a & b;
      4'h6: r = a << sh;
      4'h7: r = a >> sh;
      4'h8: r = 64'd0 - a;
      4'ha: r = a ^ b;
      4'hb: begin
        if (f == 16'd8)       r = {{56{b[7]}}, b[7:0]};
        else if (f == 16'd16) r = {{48{b[15]}}, b[15:0]};
        else if (f == 16'd32) r = {{32{b[31]}}, b[31:0]};
        else                  r = b;
      end
      4'hc: begin
        if (w) r = $signed(a) >>> sh;
        else begin x = int'(a[31:0]); x = x >>> sh; r = {32'h0, x}; end
      end
      4'h3, 4'h9: begin
        if (f == 16'd1) begin
          sa = w ? longint'(a) : longint'(int'(a[31:0]));
          sb = w ? longint'(b) : longint'(int'(b[31:0]));
          if (sb == 0)       r = (o == 4'h3) ? 64'd0 : a;
          else if (sb == -1) r = (o == 4'h3) ? 64'(-sa) : 64'd0;
          else               r = (o == 4'h3) ? 64'(sa / sb) : 64'(sa % sb);
        end else begin
          if (b == 0) r = (o == 4'h3) ? 64'd0 : a;
          else        r = (o == 4'h3) ? a / b : a % b;
        end
      end
      default: r = a;
    endcase
    if (!w) r[63:32] = 32'h0;
    return r;
  endfunction

  task automatic run(input logic [3:0] o, input logic [15:0] f, input logic w,
      input logic ur, input logic [63:0] d, input logic [63:0] s,
      output logic [63:0] res, output int lat);
    @(negedge clk);
    op = o; ofs = f; wide = w; use_reg = ur; dst_in = d; src_in = s; imm = s[31:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    res = result;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R10 watchdog act=running exp=finished");
    report();
    $finish;
  end

  initial begin
    logic [63:0] res, exp, bm;
    int lat;
    string t;
    logic [15:0] f;
    rst_n = 1'b0; start = 1'b0; op = '0; ofs = '0; wide = 1'b1; use_reg = 1'b0;
    dst_in = '0; src_in = '0; imm = '0;
    repeat (3) @(negedge clk);
    chk("R11 busy", {63'd0, busy}, 64'd0);
    chk("R11 done", {63'd0, done}, 64'd0);
    chk("R11 result", result, 64'd0);
    rst_n = 1'b1;

    // Sweep: R2 operand source, R3 32-bit mode, R4 immediate extension, R8/R9 corners
    for (int w = 0; w < 2; w++)
      for (int ur = 0; ur < 2; ur++)
        for (int o = 0; o < 13; o++)
          for (int v = 0; v < 4; v++) begin
            if (o == 3 || o == 9) begin
              if (v > 1) continue;
              f = 16'(v);
            end else if (o == 11) begin
              f = (v == 0) ? 16'd0 : (v == 1) ? 16'd8 : (v == 2) ? 16'd16 : 16'd32;
            end else begin
              if (v > 0) continue;
              f = 16'd0;
            end
            for (int i = 0; i < 11; i++)
              for (int j = 0; j < 11; j++) begin
                run(4'(o), f, w[0], ur[0], val(i), val(j), res, lat);
                exp = model(4'(o), f, w[0], ur[0], val(i), val(j), val(j) & 64'hffff_ffff);
                t = (o == 3 || o == 9) ? "R7" : (o == 6 || o == 7 || o == 12) ? "R5" :
                    (o == 11 && f != 0) ? "R6" : "R1";
                bm = ur ? val(j) : {{32{val(j)[31]}}, val(j)[31:0]};
                if (w == 0) bm = {32'h0, bm[31:0]};
                if ((o == 3 || o == 9) && bm == 0) t = {t, " R8"};
                if ((o == 3 || o == 9) && f == 1 && bm == (w ? 64'hffff_ffff_ffff_ffff : 64'hffff_ffff))
                  t = {t, " R9"};
                t = {t, (w != 0) ? ((ur != 0) ? "" : " R4") : " R3", " R2"};
                chk(t, res, exp);
                if (o == 3 || o == 9) chk({t, " R10 latency"}, 64'(lat), (w != 0) ? 64'd65 : 64'd33);
                else                  chk({t, " R1 latency"}, 64'(lat), 64'd1);
              end
          end

    // R10: second start during a running divide is ignored
    @(negedge clk);
    op = 4'h3; ofs = 16'd0; wide = 1'b1; use_reg = 1'b1; dst_in = 64'd100; src_in = 64'd7;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    chk("R10 busy during divide", {63'd0, busy}, 64'd1);
    repeat (4) begin @(negedge clk); lat++; end
    op = 4'h0; dst_in = 64'd5; src_in = 64'd5; start = 1'b1;
    @(negedge clk);
    lat++;
    start = 1'b0;
    chk("R10 no early done", {63'd0, done}, 64'd0);
    while (!done && lat < 200) begin @(negedge clk); lat++; end
    chk("R10 ignored start latency", 64'(lat), 64'd65);
    chk("R10 ignored start result", result, 64'd14);
    // R12: result holds with no new completion
    repeat (3) @(negedge clk);
    chk("R12 result held", result, 64'd14);
    chk("R12 done low", {63'd0, done}, 64'd0);

    report();
    $finish;
  end
endmodule